// File: doc/BRIEF.md
# Dual-Input Logic and Deglitch Conditioner

This block conditions a pair of digital inputs, called A and B, on their way into a pin's counting or measuring logic. Both raw inputs are first brought into the clock domain by a multi-flop synchronizer. A 3-bit mode field then picks one of two kinds of treatment. The first kind passes A and B straight through, or replaces the A path with a logic combination of the two inputs. The second kind runs both inputs through a deglitcher that only accepts a new level once three consecutive samples agree.

The deglitcher samples at a rate taken from one of four shared rate settings. Each setting is a power-of-two exponent, so its strobe fires once every 2^exponent system clocks. Every conditioner in a chip can share the same four settings. The strobes come from one free-running counter that is cleared by reset.

Top module: `pin_input_conditioner`

## Requirements
- R1: With mode 3'b000, a_out follows A and b_out follows B.
- R2: With mode 3'b001, a_out is A AND B and b_out follows B.
- R3: With mode 3'b010, a_out is A OR B and b_out follows B.
- R4: With mode 3'b011, a_out is A XOR B and b_out follows B.
- R5: With mode[2]=1, both a_out and b_out are the deglitched A and B. The filters use rate setting mode[1:0], and each channel is filtered on its own.
- R6: A filtered output takes the new sample's value only when that sample and the two samples before it are equal. Otherwise the output holds its previous value, and it never changes except on a sample strobe. A pulse that covers only two strobes is rejected.
- R7: Rate setting k is the field rate_exp[4k+3:4k], an exponent e. Its strobe fires every 2^e clocks and is aligned to a counter that reset clears. A level held for 3·2^e clocks plus the synchronizer delay is always accepted.
- R8: A raw input change reaches the logic paths after exactly two rising clock edges, which is the synchronizer depth.
- R9: Reset clears the synchronizer, the sample history and the filtered outputs to 0. After reset, a constant 1 on the input therefore needs three strobes before the filtered output rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_raw | input | 1 | Unsynchronized A input |
| b_raw | input | 1 | Unsynchronized B input |
| mode | input | 3 | Conditioning mode select |
| rate_exp | input | 16 | Four shared strobe exponents, 4 bits each, setting k at bits 4k+3:4k |
| a_out | output | 1 | Conditioned A |
| b_out | output | 1 | Conditioned B |

## Verification
On every cycle, the assertions check four things. The first is that each logic mode produces its function of the raw inputs as they were two edges earlier. The second is that a filtered output never moves except on a cycle after the selected strobe. The third is that the filtered state stays at zero during reset. The fourth is that the strobe counter holds at zero in reset and then advances by one each clock. Only the bench scenarios can show that pulses covering two strobes are rejected while sustained levels are accepted, at each of the four rates. The same scenarios show that the rate is chosen by mode[1:0], that the two channels are filtered independently, and that three samples are needed after reset.

// File: rtl/pic_pkg.sv
package pic_pkg;

   localparam int PIC_MODE_W    = 3;
   localparam int PIC_NUM_RATES = 4;
   localparam int PIC_NUM_CH    = 2;

   typedef enum logic [PIC_MODE_W-1:0] {
      PIC_PASS  = 3'b000,
      PIC_AND   = 3'b001,
      PIC_OR    = 3'b010,
      PIC_XOR   = 3'b011,
      PIC_FILT0 = 3'b100,
      PIC_FILT1 = 3'b101,
      PIC_FILT2 = 3'b110,
      PIC_FILT3 = 3'b111
   } pic_mode_e;

   function automatic logic pic_is_filtered(input logic [PIC_MODE_W-1:0] m);
      return m[PIC_MODE_W-1];
   endfunction

endpackage

// File: rtl/pic_sync.sv
module pic_sync #(
   parameter int WIDTH  = 2,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("pic_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("pic_sync: WIDTH must be at least 1");
   end

   logic [STAGES-1:0][WIDTH-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain <= '0;
      end else begin
         chain <= {chain[STAGES-2:0], d};
      end
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/pic_strobe_gen.sv
module pic_strobe_gen #(
   parameter int NUM_RATES = 4,
   parameter int EXP_W     = 4
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [NUM_RATES*EXP_W-1:0] rate_exp,
   output logic [NUM_RATES-1:0]       strobe,
   output logic [(1<<EXP_W)-2:0]      tick_cnt
);

   localparam int CNT_W = (1 << EXP_W) - 1;

   if (EXP_W < 1 || EXP_W > 5) begin : g_bad_exp
      $error("pic_strobe_gen: EXP_W must lie in 1..5");
   end
   if (NUM_RATES < 1) begin : g_bad_rates
      $error("pic_strobe_gen: NUM_RATES must be at least 1");
   end

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else begin
         cnt <= cnt + CNT_W'(1);
      end
   end

   assign tick_cnt = cnt;

   for (genvar k = 0; k < NUM_RATES; k++) begin : g_rate
      logic [EXP_W-1:0] e;
      logic [CNT_W-1:0] low_mask;
      assign e        = rate_exp[k*EXP_W +: EXP_W];
      assign low_mask = ~({CNT_W{1'b1}} << e);
      assign strobe[k] = ((cnt & low_mask) == '0);
   end

endmodule

// File: rtl/pic_vote_filter.sv
module pic_vote_filter (
   input  logic clk,
   input  logic rst_n,
   input  logic sample_en,
   input  logic din,
   output logic q
);

   logic [1:0] hist;
   logic       unanimous;

   assign unanimous = (din == hist[0]) && (din == hist[1]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hist <= '0;
         q    <= 1'b0;
      end else if (sample_en) begin
         hist <= {hist[0], din};
         if (unanimous) begin
            q <= din;
         end
      end
   end

endmodule

// File: rtl/pin_input_conditioner.sv
module pin_input_conditioner
   import pic_pkg::*;
#(
   parameter int EXP_W       = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           a_raw,
   input  logic                           b_raw,
   input  logic [PIC_MODE_W-1:0]          mode,
   input  logic [PIC_NUM_RATES*EXP_W-1:0] rate_exp,
   output logic                           a_out,
   output logic                           b_out
);

   localparam int CNT_W = (1 << EXP_W) - 1;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("pin_input_conditioner: SYNC_STAGES must be at least 2");
   end

   logic [PIC_NUM_CH-1:0]    raw_pair;
   logic [PIC_NUM_CH-1:0]    sync_pair;
   logic [PIC_NUM_CH-1:0]    filt_q;
   logic [PIC_NUM_RATES-1:0] strobes;
   logic [CNT_W-1:0]         tick_cnt;
   logic                     sel_strobe;
   logic                     a_s;
   logic                     b_s;

   assign raw_pair = {b_raw, a_raw};

   pic_sync #(.WIDTH(PIC_NUM_CH), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (raw_pair),
      .q     (sync_pair)
   );

   assign a_s = sync_pair[0];
   assign b_s = sync_pair[1];

   pic_strobe_gen #(.NUM_RATES(PIC_NUM_RATES), .EXP_W(EXP_W)) u_strobe (
      .clk      (clk),
      .rst_n    (rst_n),
      .rate_exp (rate_exp),
      .strobe   (strobes),
      .tick_cnt (tick_cnt)
   );

   assign sel_strobe = strobes[mode[1:0]];

   for (genvar ch = 0; ch < PIC_NUM_CH; ch++) begin : g_chan
      pic_vote_filter u_vote (
         .clk       (clk),
         .rst_n     (rst_n),
         .sample_en (sel_strobe),
         .din       (sync_pair[ch]),
         .q         (filt_q[ch])
      );
   end

   always_comb begin
      a_out = a_s;
      b_out = b_s;
      if (pic_is_filtered(mode)) begin
         a_out = filt_q[0];
         b_out = filt_q[1];
      end else begin
         case (pic_mode_e'(mode))
            PIC_AND: a_out = a_s & b_s;
            PIC_OR:  a_out = a_s | b_s;
            PIC_XOR: a_out = a_s ^ b_s;
            default: a_out = a_s;
         endcase
      end
   end

endmodule

// File: rtl/pin_input_conditioner_chk.sv
module pin_input_conditioner_chk #(
   parameter int LAT   = 2,
   parameter int CNT_W = 15
) (
   input logic             clk,
   input logic             rst_n,
   input logic             a_raw,
   input logic             b_raw,
   input logic [2:0]       mode,
   input logic             a_out,
   input logic             b_out,
   input logic [1:0]       filt_q,
   input logic             sel_strobe,
   input logic [CNT_W-1:0] tick_cnt
);

   logic [1:0] since_rst;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         since_rst <= '0;
      end else if (since_rst != 2'd3) begin
         since_rst <= since_rst + 2'd1;
      end
   end

   if (LAT == 2) begin : g_lat2
      // R1
      pass_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (since_rst >= 2'd2 && mode == 3'b000) |->
            (a_out == $past(a_raw, 2) && b_out == $past(b_raw, 2)));
      // R2
      and_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (since_rst >= 2'd2 && mode == 3'b001) |->
            (a_out == ($past(a_raw, 2) & $past(b_raw, 2)) && b_out == $past(b_raw, 2)));
      // R3
      or_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (since_rst >= 2'd2 && mode == 3'b010) |->
            (a_out == ($past(a_raw, 2) | $past(b_raw, 2)) && b_out == $past(b_raw, 2)));
      // R4
      xor_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (since_rst >= 2'd2 && mode == 3'b011) |->
            (a_out == ($past(a_raw, 2) ^ $past(b_raw, 2)) && b_out == $past(b_raw, 2)));
   end

   // R6
   a_move_on_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst >= 2'd1 && filt_q[0] != $past(filt_q[0])) |-> $past(sel_strobe));
   // R6
   b_move_on_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst >= 2'd1 && filt_q[1] != $past(filt_q[1])) |-> $past(sel_strobe));
   // R5
   filt_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mode[2] |-> (a_out == filt_q[0] && b_out == filt_q[1]));
   // R9
   reset_clear_chk: assert property (@(posedge clk)
      !rst_n |-> (filt_q == 2'b00 && tick_cnt == '0));
   // R7
   tick_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      since_rst >= 2'd1 |-> tick_cnt == $past(tick_cnt) + CNT_W'(1));

endmodule

bind pin_input_conditioner pin_input_conditioner_chk #(
   .LAT   (SYNC_STAGES),
   .CNT_W (CNT_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .a_raw      (a_raw),
   .b_raw      (b_raw),
   .mode       (mode),
   .a_out      (a_out),
   .b_out      (b_out),
   .filt_q     (filt_q),
   .sel_strobe (sel_strobe),
   .tick_cnt   (tick_cnt)
);

// File: tb/pin_input_conditioner_bench.sv
module pin_input_conditioner_bench;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        a_raw;
   logic        b_raw;
   logic [2:0]  mode;
   logic [15:0] rate_exp;
   logic        a_out;
   logic        b_out;

   int errors = 0;
   int checks = 0;
   bit done   = 1'b0;

   // exponents per setting: setting0=0, setting1=2, setting2=1, setting3=3
   localparam logic [15:0] RATES = {4'd3, 4'd1, 4'd2, 4'd0};

   always #2 clk = ~clk;

   pin_input_conditioner u_pin_input_conditioner (
      .clk      (clk),
      .rst_n    (rst_n),
      .a_raw    (a_raw),
      .b_raw    (b_raw),
      .mode     (mode),
      .rate_exp (rate_exp),
      .a_out    (a_out),
      .b_out    (b_out)
   );

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input logic got, input logic exp, input string req, input string what);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s %s: got %0b expected %0b", req, what, got, exp);
      end
   endtask

   function automatic int period_of(input int k);
      return 1 << int'(RATES[k*4 +: 4]);
   endfunction

   initial begin
      rst_n    = 1'b0;
      a_raw    = 1'b1;
      b_raw    = 1'b1;
      mode     = 3'b100;
      rate_exp = RATES;
      tick(4);
      // R9: outputs held low during reset with inputs high
      check(a_out, 1'b0, "R9", "a_out in reset");
      check(b_out, 1'b0, "R9", "b_out in reset");
      rst_n = 1'b1;
      // R9: history starts at 0, so the third strobe of 1s is needed (every-clock rate)
      tick(4);
      check(a_out, 1'b0, "R9", "a_out after four edges");
      tick(1);
      check(a_out, 1'b1, "R9", "a_out after fifth edge");
      check(b_out, 1'b1, "R9", "b_out after fifth edge");

      // R8: two-edge synchronizer latency in pass mode
      mode  = 3'b000;
      a_raw = 1'b0;
      b_raw = 1'b0;
      tick(4);
      a_raw = 1'b1;
      tick(1);
      check(a_out, 1'b0, "R8", "a_out one edge after change");
      tick(1);
      check(a_out, 1'b1, "R8", "a_out two edges after change");

      // R1..R4: exhaustive logic-mode sweep
      for (int m = 0; m < 4; m++) begin
         for (int v = 0; v < 4; v++) begin
            logic ea;
            logic av;
            logic bv;
            string tag;
            av = v[0];
            bv = v[1];
            mode  = 3'(m);
            a_raw = av;
            b_raw = bv;
            tick(3);
            case (m)
               0: begin ea = av;      tag = "R1"; end
               1: begin ea = av & bv; tag = "R2"; end
               2: begin ea = av | bv; tag = "R3"; end
               default: begin ea = av ^ bv; tag = "R4"; end
            endcase
            check(a_out, ea, tag, $sformatf("a_out mode %0d a=%0b b=%0b", m, av, bv));
            check(b_out, bv, tag, $sformatf("b_out mode %0d a=%0b b=%0b", m, av, bv));
         end
      end

      // R5, R6, R7: deglitch at each of the four rates
      for (int k = 0; k < 4; k++) begin
         int p;
         p     = period_of(k);
         a_raw = 1'b0;
         b_raw = 1'b0;
         mode  = 3'(4 + k);
         tick(4 * 8 + 8);
         check(a_out, 1'b0, "R5", $sformatf("a_out settled low rate %0d", k));
         check(b_out, 1'b0, "R5", $sformatf("b_out settled low rate %0d", k));
         // R6: high pulse covering two strobes is rejected
         a_raw = 1'b1;
         tick(2 * p);
         a_raw = 1'b0;
         tick(4 * p + 4);
         check(a_out, 1'b0, "R6", $sformatf("2-strobe high glitch rate %0d", k));
         // R7: sustained level accepted within 3 periods plus latency
         a_raw = 1'b1;
         tick(4 * p + 4);
         check(a_out, 1'b1, "R7", $sformatf("sustained high rate %0d", k));
         check(b_out, 1'b0, "R5", $sformatf("b_out independent of A rate %0d", k));
         // R6: low pulse covering two strobes is rejected
         a_raw = 1'b0;
         tick(2 * p);
         a_raw = 1'b1;
         tick(4 * p + 4);
         check(a_out, 1'b1, "R6", $sformatf("2-strobe low glitch rate %0d", k));
         // R5: B path filtered too
         b_raw = 1'b1;
         tick(2 * p);
         b_raw = 1'b0;
         tick(4 * p + 4);
         check(b_out, 1'b0, "R6", $sformatf("b 2-strobe glitch rate %0d", k));
         b_raw = 1'b1;
         tick(4 * p + 4);
         check(b_out, 1'b1, "R5", $sformatf("b sustained high rate %0d", k));
         a_raw = 1'b0;
         b_raw = 1'b0;
         tick(4 * p + 4);
         check(a_out, 1'b0, "R7", $sformatf("a back low rate %0d", k));
         check(b_out, 1'b0, "R7", $sformatf("b back low rate %0d", k));
      end

      // R5: rate chosen by mode[1:0]; an 8-clock pulse passes at rate 0, is rejected at rate 1
      mode  = 3'b101;
      a_raw = 1'b1;
      tick(8);
      a_raw = 1'b0;
      tick(24);
      check(a_out, 1'b0, "R5", "8-clock pulse rejected at setting 1");
      mode  = 3'b100;
      tick(8);
      a_raw = 1'b1;
      tick(8);
      check(a_out, 1'b1, "R5", "8-clock pulse accepted at setting 0");
      a_raw = 1'b0;
      tick(8);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(4 * 200000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule